// File: doc/BRIEF.md
# Burst ROM Access Controller

This block reads a run of consecutive words from a page-mode ROM. The ROM sits on one of several chip-select areas. A requester presents an area index, a start byte address and the ROM's data port width. The block then takes that area's burst field and wait-state count from static configuration inputs and runs the whole access. Chip select and the read strobe stay low for every beat of the run. Between beats only the address moves. The block returns each captured word with a one-cycle valid strobe and pulses `done` after the final word.

Each area has a 2-bit burst field. Zero gives an ordinary single read. Any non-zero value selects a burst of 4, 8 or 16 beats, limited by what the port width allows. The ROM can stretch any beat through a synchronous WAIT input. The rules for when that input is looked at differ between the first beat and the later beats.

Top module: `brom_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `rom_cs_n` and `rom_rd_n` are 1, `rd_valid` and `done` are 0, and `req_ready` is 1.
- R2: Area k takes its burst field from `cfg_burst[2k+1:2k]` and its wait count from `cfg_wait[WAIT_W*k +: WAIT_W]`. A burst field of 0 gives exactly one beat. An area index of `N_AREAS` or above is treated as a single beat with zero waits.
- R3: From the cycle after a request is accepted until the cycle in which the last beat completes, `rom_cs_n` and `rom_rd_n` are both held at 0 without a break.
- R4: Burst field 1, 2 and 3 give 4, 8 and 16 beats. Width code 0 is 8 bits, code 1 is 16 bits, and codes 2 and 3 are 32 bits. A 16-bit port is clamped to at most 8 beats and a 32-bit port to at most 4.
- R5: The first address is the start address rounded down to the port width in bytes (1, 2 or 4). Each later beat adds that width. The address wraps inside the aligned block of beats×width bytes and does not change during a beat.
- R6: With W configured waits, the first beat lasts 1+W cycles. WAIT (active high) is sampled on the last of those cycles only if W≥1, and each cycle in which it is sampled high adds one cycle. With W=0, WAIT has no effect on the first beat.
- R7: Every later beat lasts max(2, 1+W) cycles. WAIT is always sampled on its last cycle, and each high sample adds one cycle.
- R8: `rd_valid` is high for one cycle right after the cycle in which a beat completes. `rd_data` then holds the `rom_data` value present on that completing cycle.
- R9: `done` is high for one cycle after the last beat completes, and `rom_cs_n` and `rom_rd_n` are 1 in that cycle. `req_ready` is 1 exactly when no access is running. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1, and chip select goes low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_burst | input | 2*N_AREAS | Per-area burst field |
| cfg_wait | input | WAIT_W*N_AREAS | Per-area wait-state count |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_area | input | AREA_IDX_W | Area index of the request |
| req_addr | input | ADDR_W | Start byte address |
| req_width | input | 2 | Port width code (0: 8, 1: 16, 2/3: 32 bits) |
| rom_cs_n | output | 1 | Chip select, active low |
| rom_rd_n | output | 1 | Read strobe, active low |
| rom_addr | output | ADDR_W | ROM byte address |
| rom_wait | input | 1 | Synchronous wait request, active high |
| rom_data | input | DATA_W | ROM read data |
| rd_valid | output | 1 | Captured word valid |
| rd_data | output | DATA_W | Captured word |
| done | output | 1 | Burst finished pulse |

## Verification
A wrong beat counter or a wrong clamp shows at the ports as a chip select that releases too early or too late. It also shows as the wrong number of valid strobes before `done`, and the difference appears on the cycle where the last beat should end. A wrong cycle counter or wrong WAIT sampling moves the next `rd_valid` by one cycle or more, so it is caught on the first affected beat. A fault in the address register shows on `rom_addr` in the cycle after the beat edge, and on `rd_data` one cycle later. The bench's reference model predicts every port on every cycle, so none of these faults can go unnoticed for more than one beat.

// File: rtl/brom_pkg.sv
package brom_pkg;

  typedef enum logic [1:0] {
    PW_8    = 2'd0,
    PW_16   = 2'd1,
    PW_32   = 2'd2,
    PW_32B  = 2'd3
  } port_w_e;

  localparam int BEAT_W = 5;

  // beats in one access from the burst field and port width, clamped per width
  function automatic logic [BEAT_W-1:0] burst_beats(input logic [1:0] fld,
                                                    input logic [1:0] pw);
    logic [BEAT_W-1:0] n;
    case (fld)
      2'd0:    n = 5'd1;
      2'd1:    n = 5'd4;
      2'd2:    n = 5'd8;
      default: n = 5'd16;
    endcase
    if (pw == PW_16 && n > 5'd8) n = 5'd8;
    if (pw[1] && n > 5'd4) n = 5'd4;
    return n;
  endfunction

  // bytes per beat for a width code
  function automatic logic [2:0] step_bytes(input logic [1:0] pw);
    case (pw)
      PW_8:    return 3'd1;
      PW_16:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/brom_cfg_sel.sv
module brom_cfg_sel
  import brom_pkg::*;
#(
  parameter int N_AREAS    = 3,
  parameter int WAIT_W     = 3,
  parameter int AREA_IDX_W = 2
) (
  input  logic [2*N_AREAS-1:0]      cfg_burst,
  input  logic [WAIT_W*N_AREAS-1:0] cfg_wait,
  input  logic [AREA_IDX_W-1:0]     area,
  input  logic [1:0]                pw,
  output logic [BEAT_W-1:0]         beats,
  output logic [WAIT_W-1:0]         waits
);

  logic [1:0]        fld_a [N_AREAS];
  logic [WAIT_W-1:0] wt_a  [N_AREAS];

  for (genvar g = 0; g < N_AREAS; g++) begin : g_area
    assign fld_a[g] = cfg_burst[2*g +: 2];
    assign wt_a[g]  = cfg_wait[WAIT_W*g +: WAIT_W];
  end

  logic [1:0] fld;

  always_comb begin
    fld   = 2'd0;
    waits = '0;
    for (int i = 0; i < N_AREAS; i++) begin
      if (int'(area) == i) begin
        fld   = fld_a[i];
        waits = wt_a[i];
      end
    end
  end

  assign beats = burst_beats(fld, pw);

endmodule

// File: rtl/brom_beat_timer.sv
module brom_beat_timer #(
  parameter int WAIT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              first,
  input  logic [WAIT_W-1:0] waits,
  input  logic              rom_wait,
  output logic              at_limit,
  output logic              sample_en,
  output logic              beat_end
);

  localparam int CNT_W = WAIT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len;
  logic             stall;

  always_comb begin
    len = {1'b0, waits} + CNT_W'(1);
    if (!first && len < CNT_W'(2)) len = CNT_W'(2);
  end

  assign at_limit  = (cnt_q == len - CNT_W'(1));
  assign sample_en = !first || (waits != '0);
  assign stall     = at_limit && sample_en && rom_wait;
  assign beat_end  = run && at_limit && !stall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || beat_end) begin
      cnt_q <= '0;
    end else if (!at_limit) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/brom_addr_gen.sv
module brom_addr_gen
  import brom_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        pw_load,
  input  logic [1:0]        pw,
  input  logic [BEAT_W-1:0] beats,
  input  logic              advance,
  output logic [ADDR_W-1:0] addr
);

  function automatic logic [ADDR_W-1:0] align_down(input logic [ADDR_W-1:0] a,
                                                   input logic [1:0] w);
    logic [ADDR_W-1:0] s;
    s = ADDR_W'(step_bytes(w));
    return a & ~(s - ADDR_W'(1));
  endfunction

  function automatic logic [ADDR_W-1:0] wrap_next(input logic [ADDR_W-1:0] a,
                                                  input logic [1:0] w,
                                                  input logic [BEAT_W-1:0] n);
    logic [ADDR_W-1:0] s, blk, mask;
    s    = ADDR_W'(step_bytes(w));
    blk  = ADDR_W'(n) * s;
    mask = blk - ADDR_W'(1);
    return (a & ~mask) | ((a + s) & mask);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= align_down(start_addr, pw_load);
    end else if (advance) begin
      addr <= wrap_next(addr, pw, beats);
    end
  end

endmodule

// File: rtl/brom_ctrl.sv
module brom_ctrl
  import brom_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 32,
  parameter int WAIT_W     = 3,
  parameter int N_AREAS    = 3,
  parameter int AREA_IDX_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [2*N_AREAS-1:0]      cfg_burst,
  input  logic [WAIT_W*N_AREAS-1:0] cfg_wait,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [AREA_IDX_W-1:0]     req_area,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic [1:0]                req_width,
  output logic                      rom_cs_n,
  output logic                      rom_rd_n,
  output logic [ADDR_W-1:0]         rom_addr,
  input  logic                      rom_wait,
  input  logic [DATA_W-1:0]         rom_data,
  output logic                      rd_valid,
  output logic [DATA_W-1:0]         rd_data,
  output logic                      done
);

  logic              busy_q;
  logic [BEAT_W-1:0] beat_idx_q;
  logic [BEAT_W-1:0] beats_q;
  logic [WAIT_W-1:0] waits_q;
  logic [1:0]        pw_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;

  logic [BEAT_W-1:0] sel_beats;
  logic [WAIT_W-1:0] sel_waits;

  // named events for the checker
  logic accept;
  logic first_beat;
  logic at_limit;
  logic sample_en;
  logic beat_end;
  logic last_end;

  assign accept     = req_valid && !busy_q;
  assign first_beat = (beat_idx_q == '0);
  assign last_end   = beat_end && (beat_idx_q == beats_q - BEAT_W'(1));

  brom_cfg_sel #(
    .N_AREAS   (N_AREAS),
    .WAIT_W    (WAIT_W),
    .AREA_IDX_W(AREA_IDX_W)
  ) u_cfg (
    .cfg_burst(cfg_burst),
    .cfg_wait (cfg_wait),
    .area     (req_area),
    .pw       (req_width),
    .beats    (sel_beats),
    .waits    (sel_waits)
  );

  brom_beat_timer #(
    .WAIT_W(WAIT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy_q),
    .first    (first_beat),
    .waits    (waits_q),
    .rom_wait (rom_wait),
    .at_limit (at_limit),
    .sample_en(sample_en),
    .beat_end (beat_end)
  );

  brom_addr_gen #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .start_addr(req_addr),
    .pw_load   (req_width),
    .pw        (pw_q),
    .beats     (beats_q),
    .advance   (beat_end && !last_end),
    .addr      (rom_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      beat_idx_q <= '0;
      beats_q    <= BEAT_W'(1);
      waits_q    <= '0;
      pw_q       <= PW_8;
      valid_q    <= 1'b0;
      data_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      if (accept) begin
        busy_q     <= 1'b1;
        beat_idx_q <= '0;
        beats_q    <= sel_beats;
        waits_q    <= sel_waits;
        pw_q       <= req_width;
      end else if (beat_end) begin
        valid_q <= 1'b1;
        data_q  <= rom_data;
        if (last_end) begin
          busy_q     <= 1'b0;
          done_q     <= 1'b1;
          beat_idx_q <= '0;
        end else begin
          beat_idx_q <= beat_idx_q + BEAT_W'(1);
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign rom_cs_n  = !busy_q;
  assign rom_rd_n  = !busy_q;
  assign rd_valid  = valid_q;
  assign rd_data   = data_q;
  assign done      = done_q;

endmodule

// File: rtl/brom_ctrl_chk.sv
module brom_ctrl_chk #(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rom_cs_n,
  input logic              rom_rd_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              rom_wait,
  input logic              rd_valid,
  input logic              done,
  input logic              first_beat,
  input logic              at_limit,
  input logic              sample_en,
  input logic              beat_end,
  input logic              last_end
);

  p_cs_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !last_end) |=> (!rom_cs_n && !rom_rd_n));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && !beat_end) |=> $stable(rom_addr));

  p_first_nowait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && first_beat && !sample_en) |-> beat_end);

  p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_cs_n && at_limit && sample_en && rom_wait) |=> !rd_valid);

  p_min_two_later_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

  p_valid_after_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    beat_end |=> rd_valid);

  p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_end |=> (done && rom_cs_n && rom_rd_n));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rom_cs_n |-> !req_ready);

endmodule

bind brom_ctrl brom_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rom_cs_n  (rom_cs_n),
  .rom_rd_n  (rom_rd_n),
  .rom_addr  (rom_addr),
  .rom_wait  (rom_wait),
  .rd_valid  (rd_valid),
  .done      (done),
  .first_beat(first_beat),
  .at_limit  (at_limit),
  .sample_en (sample_en),
  .beat_end  (beat_end),
  .last_end  (last_end)
);

// File: tb/brom_ctrl_test.sv
module brom_ctrl_test;

  localparam int ADDR_W = 24;
  localparam int DATA_W = 32;
  localparam int WAIT_W = 3;
  localparam int NA     = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2*NA-1:0]      cfg_burst = '0;
  logic [WAIT_W*NA-1:0] cfg_wait = '0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [1:0]           req_area = '0;
  logic [ADDR_W-1:0]    req_addr = '0;
  logic [1:0]           req_width = '0;
  logic                 rom_cs_n, rom_rd_n;
  logic [ADDR_W-1:0]    rom_addr;
  logic                 rom_wait = 1'b0;
  logic [DATA_W-1:0]    rom_data;
  logic                 rd_valid;
  logic [DATA_W-1:0]    rd_data;
  logic                 done;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  function automatic logic [DATA_W-1:0] romval(input int a);
    logic [15:0] lo;
    lo = 16'(a);
    return {lo ^ 16'hA5C3, lo};
  endfunction

  assign rom_data = romval(int'(rom_addr));

  brom_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_burst(cfg_burst), .cfg_wait(cfg_wait),
    .req_valid(req_valid), .req_ready(req_ready), .req_area(req_area),
    .req_addr(req_addr), .req_width(req_width), .rom_cs_n(rom_cs_n),
    .rom_rd_n(rom_rd_n), .rom_addr(rom_addr), .rom_wait(rom_wait),
    .rom_data(rom_data), .rd_valid(rd_valid), .rd_data(rd_data), .done(done)
  );

  // expected beat count, written independently of the RTL table
  function automatic int exp_beats(input int fld, input int pw);
    int lim;
    if (fld == 0) return 1;
    lim = (pw == 0) ? 16 : (pw == 1) ? 8 : 4;
    return ((4 << (fld - 1)) < lim) ? (4 << (fld - 1)) : lim;
  endfunction

  function automatic int exp_step(input int pw);
    return (pw == 0) ? 1 : (pw == 1) ? 2 : 4;
  endfunction

  // reference model state
  bit m_busy = 0, m_valid = 0, m_done = 0;
  int m_beat, m_cyc, m_n, m_w, m_step, m_addr;
  logic [DATA_W-1:0] m_data;

  always @(posedge clk) begin
    int len, fld, blk;
    bit sampled;
    if (!rst_n) begin
      m_busy = 0; m_valid = 0; m_done = 0;
    end else begin
      m_valid = 0; m_done = 0;
      if (m_busy) begin
        m_cyc++;
        if (m_beat == 0) len = 1 + m_w;
        else len = (1 + m_w < 2) ? 2 : 1 + m_w;
        if (m_cyc >= len) begin
          sampled = (m_beat > 0) || (m_w > 0);
          if (!(sampled && rom_wait)) begin
            m_valid = 1;
            m_data = romval(m_addr);
            m_beat++;
            if (m_beat == m_n) begin
              m_busy = 0; m_done = 1;
            end else begin
              blk = m_n * m_step;
              m_addr = (m_addr / blk) * blk + ((m_addr + m_step) % blk);
              m_cyc = 0;
            end
          end
        end
      end else if (req_valid) begin
        if (int'(req_area) < NA) begin
          fld = int'(cfg_burst[2*req_area +: 2]);
          m_w = int'(cfg_wait[WAIT_W*req_area +: WAIT_W]);
        end else begin
          fld = 0; m_w = 0;
        end
        m_n = exp_beats(fld, int'(req_width));
        m_step = exp_step(int'(req_width));
        m_addr = int'(req_addr) - (int'(req_addr) % m_step);
        m_beat = 0; m_cyc = 0; m_busy = 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(req_ready == !m_busy, "R9", "req_ready", req_ready, !m_busy);
      chk(rom_cs_n == !m_busy, "R3", "rom_cs_n", rom_cs_n, !m_busy);
      chk(rom_rd_n == !m_busy, "R3", "rom_rd_n", rom_rd_n, !m_busy);
      if (m_busy)
        chk(int'(rom_addr) == m_addr, "R5", "rom_addr", rom_addr, m_addr);
      chk(rd_valid == m_valid, (m_beat <= 1) ? "R6" : "R7", "rd_valid", rd_valid, m_valid);
      if (m_valid)
        chk(rd_data == m_data, "R8", "rd_data", rd_data, m_data);
      chk(done == m_done, "R9", "done", done, m_done);
    end
  end

  task automatic run_req(input int area, input int addr, input int pw,
                         input logic [63:0] pat, input int fld_exp);
    int cnt = 0;
    int i = 1;
    int guard = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_area = 2'(area); req_addr = ADDR_W'(addr); req_width = 2'(pw);
    req_valid = 1'b1; rom_wait = pat[0];
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && guard < 3000) begin
      rom_wait = pat[i % 64];
      i++; guard++;
      @(negedge clk);
      if (rd_valid) cnt++;
    end
    rom_wait = 1'b0;
    chk(cnt == exp_beats(fld_exp, pw), (fld_exp == 0) ? "R2" : "R4",
        "beat count", cnt, exp_beats(fld_exp, pw));
    chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rom_cs_n && rom_rd_n, "R1", "strobes in reset", {rom_cs_n, rom_rd_n}, 3);
    chk(!rd_valid && !done, "R1", "pulses in reset", {rd_valid, done}, 0);
    chk(req_ready, "R1", "ready in reset", req_ready, 1);
    // area0: 4 beats, 2 waits; area1: 16 beats, 0 waits; area2: single, 1 wait
    cfg_burst = {2'd0, 2'd3, 2'd1};
    cfg_wait  = {3'd1, 3'd0, 3'd2};
    rst_n = 1'b1;
    @(negedge clk);
    chk(rom_cs_n && req_ready && !done, "R1", "first cycle after reset", rom_cs_n, 1);
    // R5 wrap in 4-byte block, R6 waits
    run_req(0, 'h103, 0, 64'h0, 1);
    // R6/R7 stalls on a 16-bit port
    run_req(0, 'h2F3, 1, 64'h0000_0000_0C36_1800, 1);
    // R6: WAIT ignored on zero-wait first beat, R7 two-cycle later beats, 16 beats
    run_req(1, 'h40A, 0, 64'h0000_0000_0000_1001, 3);
    // R4 clamps
    run_req(1, 'h40A, 2, 64'h0, 3);
    run_req(1, 'h40A, 3, 64'h0, 3);
    run_req(1, 'h51E, 1, 64'h0000_0000_0000_0241, 3);
    // R2 single access with a wait and stall
    run_req(2, 'h777, 0, 64'h0000_0000_0000_000C, 0);
    // R2 out-of-range area: single, zero waits, WAIT ignored
    run_req(3, 'h888, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    // reconfigure area0 to 8 beats, zero waits, 32-bit port -> clamp to 4, wrap
    cfg_burst[1:0] = 2'd2;
    cfg_wait[2:0]  = 3'd0;
    run_req(0, 'h2A6, 2, 64'h0, 2);
    run_req(0, 'h2A6, 0, 64'h0000_0000_0001_4100, 2);
    // back-to-back requests with a one-cycle gap
    run_req(2, 'h10, 1, 64'h0, 0);
    run_req(2, 'h20, 1, 64'h0, 0);
    run_req(1, 'hFFF, 0, 64'h0, 3);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
      finish_run();
    end
  end

endmodule